// File: doc/BRIEF.md
# Guarded Bit-Timing Configuration Loader

This block sits between the CPU write bus and the bit timer of a CAN controller. Software programs two byte-wide timing registers. One carries the baud-rate prescaler and the resynchronisation jump width. The other carries the two phase-segment lengths and a triple-sampling select. The bit timer never reads these CPU-side registers directly. It reads a working copy that is refreshed at exactly one moment: when software takes the controller out of initialization mode, which is the accepted 1-to-0 change of the init bit.

The block also decides when software may change anything. The timing registers accept writes only while the controller is in initialization mode and is not in bus-off. Any other write to them is dropped and raises a sticky rejection flag. A request to leave initialization is refused while both segment-length fields are zero. Because reset leaves the controller in initialization with every field zero, it cannot start running until software has configured it.

The reset input is asynchronous and active low. Its release is synchronized inside the block over two clock cycles.

Top module: `cbt_timing_shadow`

## Requirements
- R1: After reset, init_active is 1, wr_rejected is 0 and every working timing output is 0.
- R2: A write to address 0 or 1 while init_active is 1 and bus_off is 0 updates that CPU-side register, and the working outputs do not change.
- R3: A write to address 0 or 1 while init_active is 0 is ignored and sets wr_rejected on the next cycle.
- R4: A write to address 0 or 1 while bus_off is 1 is ignored and sets wr_rejected, even in initialization mode.
- R5: Writing address 2 with bit 0 = 0 while init_active is 1 clears init_active on the next cycle, provided the segment fields are not both zero. In the same cycle the working outputs take the CPU-side register values.
- R6: The exit request of R5 is refused while seg1 and seg2 are both zero: init_active stays 1 and the working outputs are unchanged.
- R7: While init_active stays 0, the working outputs hold their values whatever is written.
- R8: Writing address 2 with bit 0 = 1 while init_active is 0 sets init_active and clears wr_rejected on the next cycle, and leaves the working outputs unchanged.
- R9: Field layout. Address 0 holds the prescaler in bits 5:0 and the jump width in bits 7:6. Address 1 holds seg1 in bits 3:0, seg2 in bits 6:4 and triple sampling in bit 7.
- R10: Writes that change nothing have no effect on any output. These are writes to address 3, address 2 with bit 0 = 0 while init_active is 0, and address 2 with bit 0 = 1 while init_active is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 2 | CPU register address |
| wr_data | input | 8 | CPU write data |
| bus_off | input | 1 | Controller is in bus-off |
| init_active | output | 1 | Effective initialization-mode bit |
| wk_prescaler | output | 6 | Working baud-rate prescaler |
| wk_sjw | output | 2 | Working resynchronisation jump width |
| wk_seg1 | output | 4 | Working phase segment 1 length |
| wk_seg2 | output | 3 | Working phase segment 2 length |
| wk_triple | output | 1 | Working triple-sampling select |
| wr_rejected | output | 1 | Sticky flag: a timing write was refused |

## Verification
The CPU-side registers have no read path. A corrupted or wrongly accepted CPU-side value therefore stays hidden until the next accepted exit from initialization, and at that edge it shows up on every working output at once. A broken guard is different: it shows on the cycle right after the offending write, either through wr_rejected or through init_active failing to hold. The bench therefore follows every refused write with a later init round trip, so that an illegal update is pulled out to the working outputs.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int PRESC_W = 6;
  localparam int SJW_W   = 2;
  localparam int SEG1_W  = 4;
  localparam int SEG2_W  = 3;

  localparam int PRESC_LSB  = 0;
  localparam int SJW_LSB    = PRESC_LSB + PRESC_W;
  localparam int SEG1_LSB   = 0;
  localparam int SEG2_LSB   = SEG1_LSB + SEG1_W;
  localparam int TRIPLE_BIT = SEG2_LSB + SEG2_W;

  typedef enum logic [ADDR_W-1:0] {
    A_PRESC = 2'd0,
    A_SEG   = 2'd1,
    A_CTRL  = 2'd2,
    A_RSVD  = 2'd3
  } addr_e;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic [SJW_W-1:0]   sjw;
    logic [SEG1_W-1:0]  seg1;
    logic [SEG2_W-1:0]  seg2;
    logic               triple;
  } timing_t;
endpackage

// File: rtl/cbt_rst_sync.sv
module cbt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cbt_cpu_regs.sv
module cbt_cpu_regs
  import cbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              init_active,
  input  logic              bus_off,
  output timing_t           cpu_q,
  output logic              reject_evt
);
  timing_t cpu_d;
  logic    window_open;
  logic    hit_presc;
  logic    hit_seg;

  always_comb begin
    window_open = init_active && !bus_off;
    hit_presc   = wr_en && (addr_e'(wr_addr) == A_PRESC);
    hit_seg     = wr_en && (addr_e'(wr_addr) == A_SEG);
    reject_evt  = (hit_presc || hit_seg) && !window_open;
    cpu_d       = cpu_q;
    if (hit_presc && window_open) begin
      cpu_d.presc = wr_data[PRESC_LSB +: PRESC_W];
      cpu_d.sjw   = wr_data[SJW_LSB +: SJW_W];
    end
    if (hit_seg && window_open) begin
      cpu_d.seg1   = wr_data[SEG1_LSB +: SEG1_W];
      cpu_d.seg2   = wr_data[SEG2_LSB +: SEG2_W];
      cpu_d.triple = wr_data[TRIPLE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_q <= '0;
    else        cpu_q <= cpu_d;
  end
endmodule

// File: rtl/cbt_init_ctrl.sv
module cbt_init_ctrl
  import cbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              ctrl_bit,
  input  logic              seg_nonzero,
  input  logic              reject_evt,
  output logic              init_q,
  output logic              load_stb,
  output logic              flag_q
);
  logic init_d;
  logic flag_d;
  logic ctrl_hit;
  logic enter_init;

  always_comb begin
    ctrl_hit   = wr_en && (addr_e'(wr_addr) == A_CTRL);
    load_stb   = ctrl_hit && init_q && !ctrl_bit && seg_nonzero;
    enter_init = ctrl_hit && !init_q && ctrl_bit;
    init_d     = init_q;
    if (load_stb)   init_d = 1'b0;
    if (enter_init) init_d = 1'b1;
    flag_d = flag_q;
    if (reject_evt) flag_d = 1'b1;
    if (enter_init) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      init_q <= init_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/cbt_work_regs.sv
module cbt_work_regs
  import cbt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_stb,
  input  timing_t cpu_q,
  output timing_t work_q
);
  timing_t work_d;

  always_comb begin
    work_d = work_q;
    if (load_stb) work_d = cpu_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        work_q <= '0;
    else if (load_stb) work_q <= work_d;
  end
endmodule

// File: rtl/cbt_timing_shadow.sv
module cbt_timing_shadow
  import cbt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               bus_off,
  output logic               init_active,
  output logic [PRESC_W-1:0] wk_prescaler,
  output logic [SJW_W-1:0]   wk_sjw,
  output logic [SEG1_W-1:0]  wk_seg1,
  output logic [SEG2_W-1:0]  wk_seg2,
  output logic               wk_triple,
  output logic               wr_rejected
);
  logic    rst_sync_n;
  timing_t cpu_q;
  timing_t work_q;
  logic    reject_evt;
  logic    load_stb;
  logic    seg_nonzero;

  cbt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbt_cpu_regs u_cpu (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .init_active (init_active),
    .bus_off     (bus_off),
    .cpu_q       (cpu_q),
    .reject_evt  (reject_evt)
  );

  assign seg_nonzero = (cpu_q.seg1 != '0) || (cpu_q.seg2 != '0);

  cbt_init_ctrl u_ctl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .ctrl_bit    (wr_data[0]),
    .seg_nonzero (seg_nonzero),
    .reject_evt  (reject_evt),
    .init_q      (init_active),
    .load_stb    (load_stb),
    .flag_q      (wr_rejected)
  );

  cbt_work_regs u_work (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_stb (load_stb),
    .cpu_q    (cpu_q),
    .work_q   (work_q)
  );

  assign wk_prescaler = work_q.presc;
  assign wk_sjw       = work_q.sjw;
  assign wk_seg1      = work_q.seg1;
  assign wk_seg2      = work_q.seg2;
  assign wk_triple    = work_q.triple;
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
  import cbt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              bus_off,
  input logic              init_active,
  input logic              wr_rejected,
  input timing_t           cpu_q,
  input timing_t           work_q
);
  a_r3_reject_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1) && (!init_active || bus_off))
      |=> wr_rejected);

  a_r8_flag_clears_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_rejected) |-> $rose(init_active));

  a_r5_load_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_active) |-> (work_q == $past(cpu_q)));

  a_r6_exit_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (init_active && cpu_q.seg1 == '0 && cpu_q.seg2 == '0) |=> init_active);

  a_r7_work_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_active && $past(!init_active)) |-> $stable(work_q));

  a_r2_no_load_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    (init_active && $past(init_active)) |-> $stable(work_q));
endmodule

bind cbt_timing_shadow cbt_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .bus_off     (bus_off),
  .init_active (init_active),
  .wr_rejected (wr_rejected),
  .cpu_q       (cpu_q),
  .work_q      (work_q)
);

// File: tb/tb_cbt_timing_shadow.sv
module tb_cbt_timing_shadow;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       bus_off;
  logic       init_active;
  logic [5:0] wk_prescaler;
  logic [1:0] wk_sjw;
  logic [3:0] wk_seg1;
  logic [2:0] wk_seg2;
  logic       wk_triple;
  logic       wr_rejected;

  cbt_timing_shadow dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bus_off(bus_off), .init_active(init_active),
    .wk_prescaler(wk_prescaler), .wk_sjw(wk_sjw), .wk_seg1(wk_seg1),
    .wk_seg2(wk_seg2), .wk_triple(wk_triple), .wr_rejected(wr_rejected)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic       init;
    logic [7:0] r0;
    logic [7:0] r1;
    logic       flag;
    string      req;
  } exp_t;

  exp_t sb[$];
  int   n_vec  = 0;
  int   n_miss = 0;
  int   cycles = 0;
  bit   done   = 0;

  // reference model, built from the requirements
  logic       m_init;
  logic       m_flag;
  logic [7:0] m_r0, m_r1;
  logic [7:0] w_r0, w_r1;

  task automatic push_exp(input string req);
    exp_t e;
    e.init = m_init; e.r0 = w_r0; e.r1 = w_r1; e.flag = m_flag; e.req = req;
    sb.push_back(e);
  endtask

  task automatic model_write(input logic [1:0] a, input logic [7:0] d, input logic boff);
    if (a == 2'd0 || a == 2'd1) begin
      if (m_init && !boff) begin
        if (a == 2'd0) m_r0 = d;
        else           m_r1 = d;
      end else begin
        m_flag = 1'b1;
      end
    end else if (a == 2'd2) begin
      if (m_init && !d[0] && (m_r1[3:0] != 4'd0 || m_r1[6:4] != 3'd0)) begin
        m_init = 1'b0;
        w_r0 = m_r0;
        w_r1 = m_r1;
      end else if (!m_init && d[0]) begin
        m_init = 1'b1;
        m_flag = 1'b0;
      end
    end
  endtask

  task automatic drive(input logic [1:0] a, input logic [7:0] d, input logic boff,
                       input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; bus_off = boff;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    bus_off = 1'b0;
    model_write(a, d, boff);
    push_exp(req);
    wait (sb.size() == 0);
  endtask

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      logic [7:0] g0, g1;
      e  = sb.pop_front();
      g0 = {wk_sjw, wk_prescaler};
      g1 = {wk_triple, wk_seg2, wk_seg1};
      n_vec++;
      if (init_active !== e.init || g0 !== e.r0 || g1 !== e.r1 || wr_rejected !== e.flag) begin
        n_miss++;
        $display("FAIL %s: got init=%b r0=%h r1=%h flag=%b, expected init=%b r0=%h r1=%h flag=%b",
                 e.req, init_active, g0, g1, wr_rejected, e.init, e.r0, e.r1, e.flag);
      end
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      n_miss++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    wr_en = 0; wr_addr = 0; wr_data = 0; bus_off = 0;
    m_init = 1; m_flag = 0; m_r0 = 0; m_r1 = 0; w_r0 = 0; w_r1 = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    #1 push_exp("R1");                               // reset state
    wait (sb.size() == 0);

    drive(2'd2, 8'h00, 0, "R6");                     // exit refused, segs zero
    drive(2'd0, 8'h45, 0, "R2");                     // presc 5, sjw 1, no load yet
    drive(2'd1, 8'h80, 0, "R2");                     // triple only, segs zero
    drive(2'd2, 8'h00, 0, "R6");                     // still refused
    drive(2'd1, 8'hA3, 0, "R9");                     // seg1 3, seg2 2, triple 1
    drive(2'd3, 8'hFF, 0, "R10");                    // reserved address
    drive(2'd2, 8'h01, 0, "R10");                    // enter while already in init
    drive(2'd2, 8'h00, 0, "R5");                     // exit, working loaded
    drive(2'd0, 8'h3F, 0, "R3");                     // write outside init
    drive(2'd1, 8'h11, 0, "R7");                     // working held
    drive(2'd2, 8'h00, 0, "R10");                    // exit request while running
    drive(2'd2, 8'h01, 0, "R8");                     // re-enter, flag cleared
    drive(2'd2, 8'h00, 0, "R3");                     // exit: ignored writes not applied
    drive(2'd2, 8'h01, 0, "R8");
    drive(2'd1, 8'h00, 1, "R4");                     // bus-off write dropped
    drive(2'd2, 8'h00, 0, "R4");                     // exit shows seg reg kept
    drive(2'd2, 8'h01, 0, "R8");
    drive(2'd1, 8'h10, 0, "R6");                     // seg2 only nonzero
    drive(2'd0, 8'hC0, 0, "R9");                     // sjw 3, presc 0
    drive(2'd2, 8'h00, 0, "R5");                     // exit allowed with seg2 only

    repeat (2) @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule